// File: doc/BRIEF.md
# Serial transmitter with synchronous fill

This block is the sending half of a programmable serial port. A host writes one character at a time into a single-entry holding register. The block moves each character into a shift register and sends it LSB first on the serial line. Bit timing comes from a slow transmit clock input. That clock is sampled by the fast system clock, and every high-to-low transition of it is one bit-time tick. The line changes only on those ticks.

Two framings are available. In character-framed (asynchronous) mode, each character goes out as a space start bit, 5 to 8 data bits, an optional parity bit and a mark stop period. Each bit lasts 1, FACT_MID or FACT_HI ticks. In synchronous mode, bits go out at one per tick with no start or stop bits. When the host has nothing queued, the block fills the gap with one or two programmed sync characters. Framing settings, enables, clear-to-send and the break request are plain configuration inputs that a separate register block drives.

Sending is allowed only while the enable input is high and clear-to-send (active low) is asserted. A character already accepted still goes out after either of them drops.

Top module: `sertx`

## Requirements
- R1: After reset, `txd` is 1 and `txEmpty` is 1. With `txEnable` low, `txRdy` is 0.
- R2: In asynchronous mode (`cfgSync`=0), an accepted character goes out as follows: one 0 start bit, then `cfgLen`+5 data bits LSB first, then optional parity, then stop. Each start, data and parity bit lasts F ticks. F is 1 for `cfgBaud`=0, FACT_MID for 1, and FACT_HI for 2 or 3.
- R3: With `cfgParEn`=1, a parity bit follows the data bits. With `cfgParEven`=1 it makes the count of ones in data plus parity even. With `cfgParEven`=0 it makes that count odd. With `cfgParEn`=0, no parity bit is sent.
- R4: The stop period is at level 1. For `cfgStop`=0, 1 and 2/3 it lasts ceil(H*F/2) ticks, with H = 2, 3 and 4 respectively. So F=1 with `cfgStop`=1 gives 2 ticks.
- R5: `txd` changes only in the system clock cycle that follows a 1-to-0 transition of `txClkIn`. Holding `txClkIn` still freezes the line.
- R6: `txRdy` is 1 exactly when the holding register is free, `txEnable` is 1 and `ctsN` is 0.
- R7: `txEmpty` is 0 from the cycle after a write is accepted until the tick that ends that data character. Sync fill does not pull it low. In asynchronous mode an empty transmitter holds `txd` at 1.
- R8: A write is dropped when `txEnable` is 0, `ctsN` is 1, or the holding register is full. A dropped write is never sent and does not change `txEmpty`.
- R9: A character accepted before `txEnable` falls or `ctsN` rises is still sent in full.
- R10: While `sendBreak` is 1, `txd` is 0, whatever the shifter is doing.
- R11: In synchronous mode (`cfgSync`=1), characters go out at one bit per tick with no start or stop bits. At each character boundary the order is: a waiting data character first; otherwise, while enabled, sync character `syncA`, or `syncA` then `syncB` in turn when `cfgTwoSync`=1; otherwise the line returns to 1. The sync order restarts at `syncA` after a data character or after going idle.
- R12: In asynchronous mode, a character waiting at the end of the stop period starts on the very next tick, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txClkIn | input | 1 | Transmit bit clock; each falling transition is one tick |
| cfgSync | input | 1 | 1 = synchronous mode, 0 = asynchronous mode |
| cfgBaud | input | 2 | Ticks per bit in asynchronous mode: 0 = 1, 1 = FACT_MID, 2/3 = FACT_HI |
| cfgLen | input | 2 | Data bits per character minus 5 |
| cfgParEn | input | 1 | Append a parity bit |
| cfgParEven | input | 1 | 1 = even parity, 0 = odd parity |
| cfgStop | input | 2 | Stop length: 0 = 1 bit, 1 = 1.5 bits, 2/3 = 2 bits |
| cfgTwoSync | input | 1 | Sync fill alternates two characters |
| syncA | input | DATA_W | First sync character |
| syncB | input | DATA_W | Second sync character |
| txEnable | input | 1 | Transmit enable |
| ctsN | input | 1 | Clear to send, active low |
| sendBreak | input | 1 | Force the line to 0 |
| wrStb | input | 1 | One-cycle write strobe for the holding register |
| wrData | input | DATA_W | Character to write |
| txd | output | 1 | Serial data line |
| txRdy | output | 1 | Holding register can take a character |
| txEmpty | output | 1 | No data character pending or in flight |

## Verification
The bench builds the block with FACT_MID=4 and FACT_HI=8. With these values, one asynchronous frame lasts at most about a hundred ticks. That makes it practical to sweep every combination of rate code, character length, parity mode and stop length: 108 frames, each compared bit by bit against a frame built arithmetically in the bench. The small factors also keep the 1.5-stop rounding cases short: ceil(3F/2) for F=1, 4 and 8. Directed sequences cover sync fill with one and two sync characters, data pre-empting fill, draining after disable, dropped writes, the back-to-back hand-off, a frozen transmit clock and break.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
  localparam int unsigned MIN_LEN = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } txPhase_t;

  // strobes from the sequencer to the shifting datapath
  typedef struct packed {
    logic load;      // take a new character into the shifter
    logic pickSync;  // new character is a sync fill, not the holding register
    logic headOut;   // drive the first character bit at once (sync mode)
    logic spaceOut;  // drive a start bit (async mode)
    logic shiftOut;  // drive the next shifter bit
    logic markOut;   // drive the line to 1
  } txStrobe_t;
endpackage

// File: rtl/sertx_ctrl.sv
`timescale 1ns/1ps
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int unsigned FACT_MID  = 16,
  parameter int unsigned FACT_HI   = 64,
  parameter int unsigned BIT_CNT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txTick,
  input  logic       cfgSync,
  input  logic [1:0] cfgBaud,
  input  logic [1:0] cfgLen,
  input  logic       cfgParEn,
  input  logic [1:0] cfgStop,
  input  logic       allowTx,
  input  logic       holdFull,
  output txStrobe_t  strobe,
  output logic       charIsData
);
  localparam int unsigned CNT_W  = $clog2(4 * FACT_HI + 2);
  localparam int unsigned PROD_W = CNT_W + 3;

  txPhase_t               phase, phaseNxt;
  logic [CNT_W-1:0]       tickCnt, tickNxt, factor, segLen, stopTicks;
  logic [BIT_CNT_W-1:0]   bitsLeft, bitsNxt, bitsInChar;
  logic [2:0]             stopHalves;
  logic [PROD_W-1:0]      stopProd;
  logic                   isDataNxt, boundary;

  // ticks per bit and per stop period
  always_comb begin
    unique case (cfgBaud)
      2'd0:    factor = CNT_W'(1);
      2'd1:    factor = CNT_W'(FACT_MID);
      default: factor = CNT_W'(FACT_HI);
    endcase
    unique case (cfgStop)
      2'd0:    stopHalves = 3'd2;
      2'd1:    stopHalves = 3'd3;
      default: stopHalves = 3'd4;
    endcase
    stopProd   = PROD_W'(stopHalves) * PROD_W'(factor) + PROD_W'(1);
    stopTicks  = CNT_W'(stopProd >> 1);
    segLen     = cfgSync ? CNT_W'(1) : factor;
    bitsInChar = BIT_CNT_W'(MIN_LEN) + BIT_CNT_W'(cfgLen) + BIT_CNT_W'(cfgParEn);
  end

  always_comb begin
    strobe    = '0;
    phaseNxt  = phase;
    tickNxt   = tickCnt;
    bitsNxt   = bitsLeft;
    isDataNxt = charIsData;
    boundary  = 1'b0;
    if (txTick) begin
      unique case (phase)
        ST_IDLE: boundary = 1'b1;
        ST_START: begin
          if (tickCnt > CNT_W'(1)) begin
            tickNxt = tickCnt - CNT_W'(1);
          end else begin
            strobe.shiftOut = 1'b1;
            phaseNxt        = ST_BITS;
            bitsNxt         = bitsInChar - BIT_CNT_W'(1);
            tickNxt         = segLen;
          end
        end
        ST_BITS: begin
          if (tickCnt > CNT_W'(1)) begin
            tickNxt = tickCnt - CNT_W'(1);
          end else if (bitsLeft != '0) begin
            strobe.shiftOut = 1'b1;
            bitsNxt         = bitsLeft - BIT_CNT_W'(1);
            tickNxt         = segLen;
          end else if (cfgSync) begin
            boundary = 1'b1;
          end else begin
            strobe.markOut = 1'b1;
            phaseNxt       = ST_STOP;
            tickNxt        = stopTicks;
          end
        end
        ST_STOP: begin
          if (tickCnt > CNT_W'(1)) tickNxt = tickCnt - CNT_W'(1);
          else                     boundary = 1'b1;
        end
        default: phaseNxt = ST_IDLE;
      endcase

      // character boundary: data first, then sync fill, then idle
      if (boundary) begin
        if (holdFull || (cfgSync && allowTx)) begin
          strobe.load     = 1'b1;
          strobe.pickSync = !holdFull;
          isDataNxt       = holdFull;
          if (cfgSync) begin
            strobe.headOut = 1'b1;
            phaseNxt       = ST_BITS;
            bitsNxt        = bitsInChar - BIT_CNT_W'(1);
            tickNxt        = CNT_W'(1);
          end else begin
            strobe.spaceOut = 1'b1;
            phaseNxt        = ST_START;
            tickNxt         = factor;
          end
        end else begin
          strobe.markOut = 1'b1;
          phaseNxt       = ST_IDLE;
          isDataNxt      = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= ST_IDLE;
      tickCnt    <= '0;
      bitsLeft   <= '0;
      charIsData <= 1'b0;
    end else begin
      phase      <= phaseNxt;
      tickCnt    <= tickNxt;
      bitsLeft   <= bitsNxt;
      charIsData <= isDataNxt;
    end
  end
endmodule

// File: rtl/sertx_dp.sv
`timescale 1ns/1ps
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              allowTx,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParEven,
  input  logic              cfgTwoSync,
  input  logic [DATA_W-1:0] syncA,
  input  logic [DATA_W-1:0] syncB,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output logic              lineBit
);
  localparam int unsigned SH_W = DATA_W + 1;

  logic [DATA_W-1:0] holdReg, srcChar, lenMask, maskedChar;
  logic [SH_W-1:0]   frame, shiftReg;
  logic              parBit, syncIdx;

  // assemble the character: masked data with parity just above it
  always_comb begin
    srcChar = strobe.pickSync ? (syncIdx ? syncB : syncA) : holdReg;
    for (int i = 0; i < int'(DATA_W); i++)
      lenMask[i] = (i < int'(MIN_LEN) + int'(cfgLen));
    maskedChar = srcChar & lenMask;
    parBit     = cfgParEven ? (^maskedChar) : ~(^maskedChar);
    frame      = {1'b0, maskedChar};
    for (int i = 0; i < int'(SH_W); i++)
      if (cfgParEn && (i == int'(MIN_LEN) + int'(cfgLen))) frame[i] = parBit;
  end

  // single-entry holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdReg  <= '0;
    end else if (strobe.load && !strobe.pickSync) begin
      holdFull <= 1'b0;
    end else if (wrStb && allowTx && !holdFull) begin
      holdFull <= 1'b1;
      holdReg  <= wrData;
    end
  end

  // shifter and line register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      lineBit  <= 1'b1;
      syncIdx  <= 1'b0;
    end else begin
      if (strobe.load && strobe.headOut) begin
        lineBit  <= frame[0];
        shiftReg <= frame >> 1;
      end else if (strobe.load && strobe.spaceOut) begin
        lineBit  <= 1'b0;
        shiftReg <= frame;
      end else if (strobe.shiftOut) begin
        lineBit  <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (strobe.markOut) begin
        lineBit  <= 1'b1;
      end

      if (strobe.load)         syncIdx <= strobe.pickSync ? (cfgTwoSync & ~syncIdx) : 1'b0;
      else if (strobe.markOut) syncIdx <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx.sv
`timescale 1ns/1ps
module sertx
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FACT_MID = 16,
  parameter int unsigned FACT_HI  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txClkIn,
  input  logic              cfgSync,
  input  logic [1:0]        cfgBaud,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParEven,
  input  logic [1:0]        cfgStop,
  input  logic              cfgTwoSync,
  input  logic [DATA_W-1:0] syncA,
  input  logic [DATA_W-1:0] syncB,
  input  logic              txEnable,
  input  logic              ctsN,
  input  logic              sendBreak,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);
  localparam int unsigned BIT_CNT_W = $clog2(DATA_W + 2);

  logic      prevTxClk, txTick, allowTx, holdFull, lineBit, charIsData;
  txStrobe_t strobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTxClk <= 1'b0;
    else       prevTxClk <= txClkIn;
  end

  assign txTick  = prevTxClk & ~txClkIn;
  assign allowTx = txEnable & ~ctsN;

  sertx_ctrl #(
    .FACT_MID (FACT_MID),
    .FACT_HI  (FACT_HI),
    .BIT_CNT_W(BIT_CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .txTick    (txTick),
    .cfgSync   (cfgSync),
    .cfgBaud   (cfgBaud),
    .cfgLen    (cfgLen),
    .cfgParEn  (cfgParEn),
    .cfgStop   (cfgStop),
    .allowTx   (allowTx),
    .holdFull  (holdFull),
    .strobe    (strobe),
    .charIsData(charIsData)
  );

  sertx_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .wrData    (wrData),
    .allowTx   (allowTx),
    .cfgLen    (cfgLen),
    .cfgParEn  (cfgParEn),
    .cfgParEven(cfgParEven),
    .cfgTwoSync(cfgTwoSync),
    .syncA     (syncA),
    .syncB     (syncB),
    .strobe    (strobe),
    .holdFull  (holdFull),
    .lineBit   (lineBit)
  );

  assign txd     = lineBit & ~sendBreak;
  assign txRdy   = ~holdFull & allowTx;
  assign txEmpty = ~holdFull & ~charIsData;
endmodule

// File: rtl/sertx_chk.sv
`timescale 1ns/1ps
module sertx_chk (
  input logic clk,
  input logic rstN,
  input logic txTick,
  input logic lineBit,
  input logic txd,
  input logic txRdy,
  input logic txEmpty,
  input logic txEnable,
  input logic ctsN,
  input logic sendBreak,
  input logic cfgSync,
  input logic wrStb
);
  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (lineBit != $past(lineBit)) |-> $past(txTick)); // R5

  AST_RDY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    txRdy |-> (txEnable && !ctsN)); // R6

  AST_RDY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && txEnable && !ctsN) |-> txRdy); // R6

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !cfgSync && !sendBreak) |-> txd); // R7

  AST_DROPPED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !(txEnable && !ctsN) && txEmpty) |=> txEmpty); // R8
endmodule

bind sertx sertx_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .txTick   (txTick),
  .lineBit  (lineBit),
  .txd      (txd),
  .txRdy    (txRdy),
  .txEmpty  (txEmpty),
  .txEnable (txEnable),
  .ctsN     (ctsN),
  .sendBreak(sendBreak),
  .cfgSync  (cfgSync),
  .wrStb    (wrStb)
);

// File: tb/sertx_tb_top.sv
`timescale 1ns/1ps
module sertx_tb_top;
  logic       clk = 1'b0, rstN = 1'b0, txClkIn = 1'b1;
  logic       cfgSync = 1'b0, cfgParEn = 1'b0, cfgParEven = 1'b0, cfgTwoSync = 1'b0;
  logic [1:0] cfgBaud = 2'd0, cfgLen = 2'd3, cfgStop = 2'd0;
  logic [7:0] syncA = 8'h3C, syncB = 8'hC9, wrData = 8'h00;
  logic       txEnable = 1'b0, ctsN = 1'b0, sendBreak = 1'b0, wrStb = 1'b0;
  logic       txd, txRdy, txEmpty;

  int total = 0, bad = 0, expN = 0;
  bit expBits [0:1023];

  always #2.5 clk = ~clk;

  sertx #(.DATA_W(8), .FACT_MID(4), .FACT_HI(8)) dut_i (
    .clk(clk), .rstN(rstN), .txClkIn(txClkIn), .cfgSync(cfgSync), .cfgBaud(cfgBaud),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .cfgParEven(cfgParEven), .cfgStop(cfgStop),
    .cfgTwoSync(cfgTwoSync), .syncA(syncA), .syncB(syncB), .txEnable(txEnable),
    .ctsN(ctsN), .sendBreak(sendBreak), .wrStb(wrStb), .wrData(wrData),
    .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one transmit clock period; returns the line right after the tick
  task automatic tickSample(output logic v);
    @(negedge clk) txClkIn = 1'b0;
    @(negedge clk) v = txd;
    @(negedge clk) txClkIn = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeChar(input logic [7:0] d);
    @(negedge clk) begin wrStb = 1'b1; wrData = d; end
    @(negedge clk) wrStb = 1'b0;
  endtask

  task automatic pushBit(input bit b, input int cnt);
    for (int i = 0; i < cnt; i++) begin expBits[expN] = b; expN++; end
  endtask

  function automatic int factorOf(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : 8;
  endfunction

  task automatic pushAsync(input logic [7:0] d, input int lenCode, input int parMode,
                           input int stopCode, input int baud);
    int f, len, halves;
    bit p;
    f = factorOf(baud);
    len = 5 + lenCode;
    halves = (stopCode == 0) ? 2 : (stopCode == 1) ? 3 : 4;
    p = 1'b0;
    pushBit(1'b0, f);
    for (int i = 0; i < len; i++) begin pushBit(d[i], f); p ^= d[i]; end
    if (parMode != 0) pushBit((parMode == 2) ? p : ~p, f);
    pushBit(1'b1, (halves * f + 1) / 2);
  endtask

  task automatic pushSync(input logic [7:0] d);
    for (int i = 0; i < 8; i++) pushBit(d[i], 1);
  endtask

  task automatic compareRange(input int lo, input int hi, input string req);
    int mism, act, exp;
    logic v;
    mism = 0; act = 0; exp = 0;
    for (int i = lo; i < hi; i++) begin
      tickSample(v);
      if (v !== expBits[i]) begin
        if (mism == 0) begin act = int'(v); exp = int'(expBits[i]); end
        mism++;
      end
    end
    check(mism == 0, req, act, exp);
  endtask

  task automatic runAll(input string req);
    compareRange(0, expN, req);
    expN = 0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx;
    logic v;
    logic [7:0] d;
    idx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txd === 1'b1, "R1 line high after reset", int'(txd), 1);
    check(txEmpty === 1'b1, "R1 empty after reset", int'(txEmpty), 1);
    check(txRdy === 1'b0, "R1 not ready while disabled", int'(txRdy), 0);

    txEnable = 1'b1;
    @(negedge clk);
    check(txRdy === 1'b1, "R6 ready when enabled", int'(txRdy), 1);
    ctsN = 1'b1;
    @(negedge clk);
    check(txRdy === 1'b0, "R6 ready blocked by cts", int'(txRdy), 0);
    ctsN = 1'b0;

    // R2 R3 R4: every rate, length, parity and stop combination
    for (int b = 0; b < 3; b++)
      for (int l = 0; l < 4; l++)
        for (int p = 0; p < 3; p++)
          for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            cfgBaud = 2'(b); cfgLen = 2'(l); cfgStop = 2'(s);
            cfgParEn = (p != 0); cfgParEven = (p == 2);
            d = 8'(8'h5A + idx * 29);
            idx++;
            writeChar(d);
            check(txEmpty === 1'b0, "R7 empty low after write", int'(txEmpty), 0);
            pushAsync(d, l, p, s, b);
            runAll("R2/R3/R4 async frame");
            pushBit(1'b1, 1);
            runAll("R7 line idle after frame");
            check(txEmpty === 1'b1, "R7 empty after frame", int'(txEmpty), 1);
          end

    // R12: back-to-back hand-off at x1, 5 bits, no parity, one stop
    @(negedge clk);
    cfgBaud = 2'd0; cfgLen = 2'd0; cfgParEn = 1'b0; cfgStop = 2'd0;
    pushAsync(8'h13, 0, 0, 0, 0);
    pushAsync(8'h0E, 0, 0, 0, 0);
    pushBit(1'b1, 2);
    writeChar(8'h13);
    tickSample(v);
    check(v === expBits[0], "R12 first start bit", int'(v), int'(expBits[0]));
    check(txRdy === 1'b1, "R6 ready once shifter took char", int'(txRdy), 1);
    writeChar(8'h0E);
    compareRange(1, expN, "R12 next char follows stop");
    expN = 0;

    // R8: second write while full is dropped
    writeChar(8'hB7);
    writeChar(8'h48);
    check(txRdy === 1'b0, "R8 not ready while full", int'(txRdy), 0);
    pushAsync(8'hB7, 0, 0, 0, 0);
    pushBit(1'b1, 4);
    runAll("R8 write to full register dropped");
    check(txEmpty === 1'b1, "R8 empty after single char", int'(txEmpty), 1);

    // R8: writes while disabled or cts high are dropped
    txEnable = 1'b0;
    writeChar(8'h00);
    check(txEmpty === 1'b1, "R8 empty stays high when disabled", int'(txEmpty), 1);
    check(txRdy === 1'b0, "R8 not ready when disabled", int'(txRdy), 0);
    txEnable = 1'b1;
    ctsN = 1'b1;
    writeChar(8'h00);
    check(txEmpty === 1'b1, "R8 empty stays high with cts high", int'(txEmpty), 1);
    ctsN = 1'b0;
    pushBit(1'b1, 12);
    runAll("R8 dropped writes never sent");

    // R9: drain after enable falls, and after cts rises
    @(negedge clk);
    cfgLen = 2'd3; cfgParEn = 1'b1; cfgParEven = 1'b0; cfgStop = 2'd2;
    writeChar(8'hA1);
    txEnable = 1'b0;
    pushAsync(8'hA1, 3, 1, 2, 0);
    pushBit(1'b1, 2);
    runAll("R9 drain after enable cleared");
    txEnable = 1'b1;
    writeChar(8'h7E);
    ctsN = 1'b1;
    @(negedge clk);
    check(txRdy === 1'b0, "R6 not ready with cts high", int'(txRdy), 0);
    pushAsync(8'h7E, 3, 1, 2, 0);
    pushBit(1'b1, 2);
    runAll("R9 drain after cts raised");
    ctsN = 1'b0;

    // R5: frozen transmit clock freezes the line
    @(negedge clk);
    cfgBaud = 2'd2; cfgParEn = 1'b0; cfgStop = 2'd0;
    pushAsync(8'h96, 3, 0, 0, 2);
    pushBit(1'b1, 1);
    writeChar(8'h96);
    for (int i = 0; i < 9; i++) tickSample(v);
    check(v === expBits[8], "R5 first data bit", int'(v), int'(expBits[8]));
    begin
      int moved;
      moved = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (txd !== v) moved++;
      end
      check(moved == 0, "R5 line frozen without tick", moved, 0);
    end
    compareRange(9, expN, "R5 frame resumes after pause");
    expN = 0;

    // R10: break
    sendBreak = 1'b1;
    @(negedge clk);
    check(txd === 1'b0, "R10 break drives low", int'(txd), 0);
    pushBit(1'b0, 5);
    runAll("R10 break held across ticks");
    sendBreak = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R10 line back after break", int'(txd), 1);

    // R11: synchronous mode with two sync characters
    @(negedge clk);
    cfgSync = 1'b1; cfgLen = 2'd3; cfgParEn = 1'b0; cfgTwoSync = 1'b1;
    pushSync(syncA); pushSync(syncB); pushSync(8'h5D); pushSync(syncA);
    compareRange(0, 12, "R11 sync fill A then B");
    check(txEmpty === 1'b1, "R11 empty during fill", int'(txEmpty), 1);
    writeChar(8'h5D);
    check(txEmpty === 1'b0, "R7 empty low with queued data", int'(txEmpty), 0);
    compareRange(12, 32, "R11 data then fill restarts at A");
    expN = 0;
    check(txEmpty === 1'b1, "R7 empty after sync data", int'(txEmpty), 1);
    txEnable = 1'b0;
    pushBit(1'b1, 3);
    runAll("R11 fill stops when disabled");

    // R11: single sync character repeats
    @(negedge clk);
    cfgTwoSync = 1'b0; txEnable = 1'b1;
    pushSync(syncA); pushSync(syncA);
    runAll("R11 single sync repeats");
    txEnable = 1'b0;
    pushBit(1'b1, 2);
    runAll("R11 idle after single sync");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule